// File: doc/BRIEF.md
# Pin-Triggered Keyboard Scan Sequencer

This block watches one general-purpose input pin and, on each change of its level, produces the scan-code bytes that a keyboard controller expects for a key press or a key release. A rising level is a press and produces a make sequence. A falling level is a release and produces a break sequence. Per-event configuration inputs can wrap the key in left-hand Ctrl, Alt and Shift presses and a configurable prefix byte. Key codes follow scan set 2.

While the pin stays high, the key code is resent as a typematic repeat. The first repeat comes after a selectable initial delay, and later repeats follow at a selectable rate. Bytes leave one at a time on a valid/ready handshake. Edges that arrive while a sequence is still in progress are queued and played out afterwards, in the order they occurred.

Top module: `kbd_scan_seq`

## Requirements
- R1: After reset `sc_valid_o` is low, and no byte is produced until the pin changes level.
- R2: With all four wrap enables low, a rising pin edge produces exactly one byte, the configured key code.
- R3: For a press, enabled wrap bytes are sent before the key code in this fixed order: left Ctrl 0x14, left Alt 0x11, left Shift 0x12, then the prefix byte. A disabled entry is skipped.
- R4: For a release, the sequence is: the prefix byte if enabled, then 0xF0, then the key code, then the enabled modifiers released in reverse order as 0xF0 0x12, 0xF0 0x11, 0xF0 0x14.
- R5: While `sc_valid_o` is high and `sc_ready_i` is low, `sc_valid_o` stays high and `sc_byte_o` holds its value.
- R6: A pin edge that occurs during a sequence is not lost. A release followed by a press during one sequence produces a full break sequence and then a full make sequence once the current sequence ends.
- R7: While the key is held, the first repeat is accepted (d+1)*DELAY_UNIT+1 cycles after the last byte of the make sequence is accepted, where d is `cfg_delay_sel_i` and the ready input is held high.
- R8: Each repeat is the key code alone, with no modifier or prefix byte. Later repeats are accepted (r+1)*RATE_UNIT+1 cycles apart, where r is `cfg_rate_sel_i`.
- R9: Repeats stop once the pin falls. No repeat byte follows the 0xF0 of the release, even when the release arrives in the cycle the repeat timer expires.
- R10: Configuration is captured when a sequence starts. A change during a stalled sequence affects only later sequences.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| key_pin_i | input | 1 | Key pin, asynchronous, high means pressed |
| cfg_ctrl_en_i | input | 1 | Wrap the key with left Ctrl |
| cfg_alt_en_i | input | 1 | Wrap the key with left Alt |
| cfg_shift_en_i | input | 1 | Wrap the key with left Shift |
| cfg_pre_en_i | input | 1 | Send the prefix byte before the key code |
| cfg_pre_code_i | input | 8 | Prefix byte value |
| cfg_key_code_i | input | 8 | Make code of the key |
| cfg_delay_sel_i | input | DELAY_W | Initial repeat delay select |
| cfg_rate_sel_i | input | RATE_W | Repeat interval select |
| sc_ready_i | input | 1 | Consumer accepts the current byte |
| sc_valid_o | output | 1 | A byte is presented |
| sc_byte_o | output | 8 | Presented scan-code byte |

## Verification
A release edge and the expiry of the repeat timer can both be ready in the same idle cycle. When that happens, the queued edge must win, and the timer must be cleared without producing a stray key code after the break. The bench provokes this by pressing the key and then sweeping the release over a span of cycle offsets that crosses the expiry point. For every offset, it judges the stream to be some number of key codes followed by exactly 0xF0 and the key code, with nothing after. It also requires that both outcomes, with and without a repeat, actually occurred during the sweep.

// File: rtl/kss_pkg.sv
package kss_pkg;

   localparam int BYTE_W = 8;
   localparam int NSLOT  = 12;
   localparam int SLOT_W = 4;

   typedef logic [BYTE_W-1:0] kbyte_t;
   typedef logic [SLOT_W-1:0] slot_t;

   localparam kbyte_t KC_LCTRL  = 8'h14;
   localparam kbyte_t KC_LALT   = 8'h11;
   localparam kbyte_t KC_LSHIFT = 8'h12;
   localparam kbyte_t KC_BREAK  = 8'hF0;

   // Slot positions; the emission order is the slot order.
   localparam int SL_CTRL   = 0;
   localparam int SL_ALT    = 1;
   localparam int SL_SHIFT  = 2;
   localparam int SL_PRE    = 3;
   localparam int SL_BRK    = 4;
   localparam int SL_CODE   = 5;
   localparam int SL_RSH_F0 = 6;
   localparam int SL_RSH    = 7;
   localparam int SL_RAL_F0 = 8;
   localparam int SL_RAL    = 9;
   localparam int SL_RCT_F0 = 10;
   localparam int SL_RCT    = 11;

   typedef enum logic [1:0] {
      EV_MAKE   = 2'd0,
      EV_BREAK  = 2'd1,
      EV_REPEAT = 2'd2
   } kss_ev_e;

   typedef struct packed {
      logic ctrl;
      logic alt;
      logic shift;
      logic pre;
   } kss_mods_t;

   function automatic logic [NSLOT-1:0] slot_mask(kss_ev_e ev, kss_mods_t m);
      logic [NSLOT-1:0] r;
      logic mk, bk;
      mk = (ev == EV_MAKE);
      bk = (ev == EV_BREAK);
      r = '0;
      r[SL_CTRL]   = mk & m.ctrl;
      r[SL_ALT]    = mk & m.alt;
      r[SL_SHIFT]  = mk & m.shift;
      r[SL_PRE]    = (mk | bk) & m.pre;
      r[SL_BRK]    = bk;
      r[SL_CODE]   = 1'b1;
      r[SL_RSH_F0] = bk & m.shift;
      r[SL_RSH]    = bk & m.shift;
      r[SL_RAL_F0] = bk & m.alt;
      r[SL_RAL]    = bk & m.alt;
      r[SL_RCT_F0] = bk & m.ctrl;
      r[SL_RCT]    = bk & m.ctrl;
      return r;
   endfunction

   function automatic kbyte_t slot_byte(slot_t s, kbyte_t code, kbyte_t pre);
      kbyte_t b;
      case (int'(s))
         SL_CTRL, SL_RCT:                  b = KC_LCTRL;
         SL_ALT, SL_RAL:                   b = KC_LALT;
         SL_SHIFT, SL_RSH:                 b = KC_LSHIFT;
         SL_PRE:                           b = pre;
         SL_BRK, SL_RSH_F0, SL_RAL_F0,
         SL_RCT_F0:                        b = KC_BREAK;
         default:                          b = code;
      endcase
      return b;
   endfunction

endpackage

// File: rtl/kss_edge.sv
module kss_edge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   input  logic take_i,
   output logic pend_o,
   output logic pend_make_o,
   output logic key_down_o
);

   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("kss_edge: SYNC_STAGES must be at least 1");
   end

   logic lvl;
   logic prev_q;
   logic rep_lvl_q;
   logic [1:0] cnt_q;
   logic [1:0] cnt_d;
   logic edge_seen;

   if (SYNC_STAGES == 1) begin : g_sync1
      logic s_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) s_q <= 1'b0;
         else        s_q <= pin_i;
      end
      assign lvl = s_q;
   end else begin : g_syncn
      logic [SYNC_STAGES-1:0] s_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) s_q <= '0;
         else        s_q <= {s_q[SYNC_STAGES-2:0], pin_i};
      end
      assign lvl = s_q[SYNC_STAGES-1];
   end

   assign edge_seen = lvl ^ prev_q;

   // Unreported edges alternate in direction; a third one cancels a pair.
   always_comb begin
      cnt_d = cnt_q;
      if (take_i && cnt_q != 2'd0) cnt_d = cnt_d - 2'd1;
      if (edge_seen) cnt_d = (cnt_d == 2'd2) ? 2'd1 : cnt_d + 2'd1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q    <= 1'b0;
         cnt_q     <= 2'd0;
         rep_lvl_q <= 1'b0;
      end else begin
         prev_q <= lvl;
         cnt_q  <= cnt_d;
         if (take_i && cnt_q != 2'd0) rep_lvl_q <= ~rep_lvl_q;
      end
   end

   assign pend_o      = (cnt_q != 2'd0);
   assign pend_make_o = ~rep_lvl_q;
   assign key_down_o  = rep_lvl_q;

   AST_PEND_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q != 2'd3);                                               // R6

   AST_TAKE_ONLY_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i && !edge_seen) |=> (cnt_q == $past(cnt_q) - 2'd1)); // R6

endmodule

// File: rtl/kss_rep_timer.sv
module kss_rep_timer #(
   parameter int DELAY_W    = 2,
   parameter int RATE_W     = 2,
   parameter int DELAY_UNIT = 250,
   parameter int RATE_UNIT  = 40
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DELAY_W-1:0] delay_sel_i,
   input  logic [RATE_W-1:0]  rate_sel_i,
   input  logic              load_delay_i,
   input  logic              load_rate_i,
   input  logic              stop_i,
   output logic              fire_o
);

   localparam int MAX_DLY = (2 ** DELAY_W) * DELAY_UNIT;
   localparam int MAX_RTE = (2 ** RATE_W) * RATE_UNIT;
   localparam int MAX_T   = (MAX_DLY > MAX_RTE) ? MAX_DLY : MAX_RTE;
   localparam int CNT_W   = (MAX_T > 2) ? $clog2(MAX_T) : 1;

   if (DELAY_W < 1 || RATE_W < 1) begin : g_bad_w
      $error("kss_rep_timer: select widths must be at least 1");
   end
   if (DELAY_UNIT < 1 || RATE_UNIT < 1) begin : g_bad_unit
      $error("kss_rep_timer: time units must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             active_q;
   logic [CNT_W-1:0] dly_ld;
   logic [CNT_W-1:0] rte_ld;

   assign dly_ld = CNT_W'((int'(delay_sel_i) + 1) * DELAY_UNIT - 1);
   assign rte_ld = CNT_W'((int'(rate_sel_i) + 1) * RATE_UNIT - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
      end else if (stop_i) begin
         active_q <= 1'b0;
      end else if (load_delay_i) begin
         active_q <= 1'b1;
         cnt_q    <= dly_ld;
      end else if (load_rate_i) begin
         active_q <= 1'b1;
         cnt_q    <= rte_ld;
      end else if (active_q && cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign fire_o = active_q && (cnt_q == '0);

   AST_STOP_KILLS_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
      stop_i |=> !fire_o);                                          // R9

endmodule

// File: rtl/kss_emitter.sv
module kss_emitter (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pend_i,
   input  logic               pend_make_i,
   output logic               take_o,
   input  logic               held_i,
   input  logic               fire_i,
   output logic               start_rep_o,
   input  kss_pkg::kss_mods_t mods_i,
   input  kss_pkg::kbyte_t    code_i,
   input  kss_pkg::kbyte_t    pre_i,
   input  logic               ready_i,
   output logic               valid_o,
   output kss_pkg::kbyte_t    data_o,
   output logic               done_make_o,
   output logic               done_rep_o
);
   import kss_pkg::*;

   logic               busy_q;
   slot_t              slot_q;
   kss_ev_e            ev_q;
   kss_mods_t          mods_q;
   kbyte_t             code_q;
   kbyte_t             pre_q;

   logic [NSLOT-1:0]   cur_mask;
   logic [NSLOT-1:0]   new_mask;
   kss_ev_e            new_ev;
   slot_t              nxt_slot;
   logic               has_nxt;
   slot_t              first_slot;
   logic               accept;
   logic               last;

   assign new_ev   = pend_make_i ? EV_MAKE : EV_BREAK;
   assign cur_mask = slot_mask(ev_q, mods_q);
   assign new_mask = slot_mask(new_ev, mods_i);

   always_comb begin
      nxt_slot = '0;
      has_nxt  = 1'b0;
      for (int i = NSLOT - 1; i >= 0; i--) begin
         if (cur_mask[i] && i > int'(slot_q)) begin
            nxt_slot = slot_t'(i);
            has_nxt  = 1'b1;
         end
      end
   end

   always_comb begin
      first_slot = slot_t'(SL_CODE);
      for (int i = NSLOT - 1; i >= 0; i--) begin
         if (new_mask[i]) first_slot = slot_t'(i);
      end
   end

   assign take_o      = !busy_q && pend_i;
   assign start_rep_o = !busy_q && !pend_i && held_i && fire_i;
   assign accept      = busy_q && ready_i;
   assign last        = !has_nxt;
   assign done_make_o = accept && last && (ev_q == EV_MAKE);
   assign done_rep_o  = accept && last && (ev_q == EV_REPEAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         slot_q <= '0;
         ev_q   <= EV_MAKE;
         mods_q <= '0;
         code_q <= '0;
         pre_q  <= '0;
      end else if (!busy_q) begin
         if (take_o) begin
            busy_q <= 1'b1;
            ev_q   <= new_ev;
            mods_q <= mods_i;
            code_q <= code_i;
            pre_q  <= pre_i;
            slot_q <= first_slot;
         end else if (start_rep_o) begin
            busy_q <= 1'b1;
            ev_q   <= EV_REPEAT;
            code_q <= code_i;
            slot_q <= slot_t'(SL_CODE);
         end
      end else if (accept) begin
         if (last) busy_q <= 1'b0;
         else      slot_q <= nxt_slot;
      end
   end

   assign valid_o = busy_q;
   assign data_o  = slot_byte(slot_q, code_q, pre_q);

   AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !ready_i) |=> (valid_o && $stable(data_o)));    // R5

   AST_REPEAT_BARE: assert property (@(posedge clk) disable iff (!rst_n)
      start_rep_o |=> (valid_o && data_o == $past(code_i)));       // R8

endmodule

// File: rtl/kbd_scan_seq.sv
module kbd_scan_seq #(
   parameter int SYNC_STAGES = 2,
   parameter int DELAY_W     = 2,
   parameter int RATE_W      = 2,
   parameter int DELAY_UNIT  = 250,
   parameter int RATE_UNIT   = 40
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               key_pin_i,
   input  logic               cfg_ctrl_en_i,
   input  logic               cfg_alt_en_i,
   input  logic               cfg_shift_en_i,
   input  logic               cfg_pre_en_i,
   input  logic [7:0]         cfg_pre_code_i,
   input  logic [7:0]         cfg_key_code_i,
   input  logic [DELAY_W-1:0] cfg_delay_sel_i,
   input  logic [RATE_W-1:0]  cfg_rate_sel_i,
   input  logic               sc_ready_i,
   output logic               sc_valid_o,
   output logic [7:0]         sc_byte_o
);
   import kss_pkg::*;

   logic      pend;
   logic      pend_make;
   logic      key_down;
   logic      take;
   logic      held;
   logic      fire;
   logic      start_rep;
   logic      done_make;
   logic      done_rep;
   logic      tmr_stop;
   kss_mods_t mods;

   assign mods     = '{ctrl: cfg_ctrl_en_i, alt: cfg_alt_en_i,
                       shift: cfg_shift_en_i, pre: cfg_pre_en_i};
   assign held     = key_down && !pend;
   assign tmr_stop = !held || start_rep;

   kss_edge #(.SYNC_STAGES(SYNC_STAGES)) i_edge (
      .clk         (clk),
      .rst_n       (rst_n),
      .pin_i       (key_pin_i),
      .take_i      (take),
      .pend_o      (pend),
      .pend_make_o (pend_make),
      .key_down_o  (key_down)
   );

   kss_rep_timer #(
      .DELAY_W    (DELAY_W),
      .RATE_W     (RATE_W),
      .DELAY_UNIT (DELAY_UNIT),
      .RATE_UNIT  (RATE_UNIT)
   ) i_timer (
      .clk          (clk),
      .rst_n        (rst_n),
      .delay_sel_i  (cfg_delay_sel_i),
      .rate_sel_i   (cfg_rate_sel_i),
      .load_delay_i (done_make),
      .load_rate_i  (done_rep),
      .stop_i       (tmr_stop),
      .fire_o       (fire)
   );

   kss_emitter i_emit (
      .clk         (clk),
      .rst_n       (rst_n),
      .pend_i      (pend),
      .pend_make_i (pend_make),
      .take_o      (take),
      .held_i      (held),
      .fire_i      (fire),
      .start_rep_o (start_rep),
      .mods_i      (mods),
      .code_i      (cfg_key_code_i),
      .pre_i       (cfg_pre_code_i),
      .ready_i     (sc_ready_i),
      .valid_o     (sc_valid_o),
      .data_o      (sc_byte_o),
      .done_make_o (done_make),
      .done_rep_o  (done_rep)
   );

   AST_BARE_MAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (take && pend_make && !cfg_ctrl_en_i && !cfg_alt_en_i &&
       !cfg_shift_en_i && !cfg_pre_en_i)
      |=> (sc_valid_o && sc_byte_o == $past(cfg_key_code_i)));     // R2

   AST_BREAK_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !pend_make)
      |=> (sc_valid_o && (sc_byte_o == KC_BREAK || $past(cfg_pre_en_i)))); // R4

   AST_NO_FIRE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      !key_down |=> !fire);                                        // R9

endmodule

// File: tb/test_kbd_scan_seq.sv
module test_kbd_scan_seq;
   localparam int DU = 16;
   localparam int RU = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pin = 1'b0;
   logic c_ctrl = 1'b0, c_alt = 1'b0, c_shift = 1'b0, c_pre = 1'b0;
   logic [7:0] c_prec = 8'hE0;
   logic [7:0] c_code = 8'h1C;
   logic [1:0] c_dly = 2'd3;
   logic [1:0] c_rte = 2'd0;
   logic rdy = 1'b1;
   logic vld;
   logic [7:0] dat;

   int checks = 0;
   int fails = 0;
   int cyc = 0;
   int n = 0;
   logic [7:0] log_b [0:1023];
   int         log_t [0:1023];
   logic [7:0] eb [0:15];
   int en = 0;

   always #5 clk = ~clk;

   kbd_scan_seq #(.SYNC_STAGES(2), .DELAY_W(2), .RATE_W(2),
                  .DELAY_UNIT(DU), .RATE_UNIT(RU)) i_kbd_scan_seq (
      .clk(clk), .rst_n(rst_n), .key_pin_i(pin),
      .cfg_ctrl_en_i(c_ctrl), .cfg_alt_en_i(c_alt),
      .cfg_shift_en_i(c_shift), .cfg_pre_en_i(c_pre),
      .cfg_pre_code_i(c_prec), .cfg_key_code_i(c_code),
      .cfg_delay_sel_i(c_dly), .cfg_rate_sel_i(c_rte),
      .sc_ready_i(rdy), .sc_valid_o(vld), .sc_byte_o(dat));

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (rst_n && vld && rdy && n < 1024) begin
         log_b[n] = dat;
         log_t[n] = cyc;
         n = n + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic cycles(input int k);
      repeat (k) @(negedge clk);
   endtask

   task automatic wait_bytes(input int target, input int limit);
      for (int i = 0; i < limit && n < target; i++) @(negedge clk);
   endtask

   task automatic ex_clear(); en = 0; endtask
   task automatic ex(input logic [7:0] b); eb[en] = b; en++; endtask

   task automatic check_seq(input string req, input string what, input int base);
      chk(n - base == en, req, {what, " length"}, n - base, en);
      for (int i = 0; i < en && i < n - base; i++)
         chk(log_b[base + i] == eb[i], req, what, log_b[base + i], eb[i]);
   endtask

   task automatic press_release_check(input string rq_m, input string rq_b,
                                      input string tag);
      int base;
      base = n;
      @(negedge clk) pin = 1'b1;
      cycles(25);
      check_seq(rq_m, {tag, " make"}, base);
      ex_clear();
   endtask

   // R1
   task automatic t_reset();
      chk(vld == 1'b0, "R1", "valid after reset", vld, 0);
      cycles(20);
      chk(n == 0 && vld == 1'b0, "R1", "quiet without edge", n, 0);
   endtask

   // R2, R4
   task automatic t_bare();
      int base;
      c_ctrl = 0; c_alt = 0; c_shift = 0; c_pre = 0; c_dly = 2'd3;
      base = n;
      ex_clear(); ex(c_code);
      @(negedge clk) pin = 1'b1;
      cycles(20);
      check_seq("R2", "bare make", base);
      base = n;
      ex_clear(); ex(8'hF0); ex(c_code);
      @(negedge clk) pin = 1'b0;
      cycles(20);
      check_seq("R4", "bare break", base);
   endtask

   // R3, R4
   task automatic t_wrap(input bit ct, input bit al, input bit sh, input bit pr);
      int base;
      c_ctrl = ct; c_alt = al; c_shift = sh; c_pre = pr; c_dly = 2'd3;
      base = n;
      ex_clear();
      if (ct) ex(8'h14);
      if (al) ex(8'h11);
      if (sh) ex(8'h12);
      if (pr) ex(c_prec);
      ex(c_code);
      @(negedge clk) pin = 1'b1;
      cycles(25);
      check_seq("R3", "wrapped make", base);
      base = n;
      ex_clear();
      if (pr) ex(c_prec);
      ex(8'hF0); ex(c_code);
      if (sh) begin ex(8'hF0); ex(8'h12); end
      if (al) begin ex(8'hF0); ex(8'h11); end
      if (ct) begin ex(8'hF0); ex(8'h14); end
      @(negedge clk) pin = 1'b0;
      cycles(25);
      check_seq("R4", "wrapped break", base);
   endtask

   // R5, R6, R10
   task automatic t_stall();
      int base;
      bit stable;
      c_ctrl = 1; c_alt = 0; c_shift = 1; c_pre = 0; c_code = 8'h1C;
      rdy = 1'b0;
      base = n;
      @(negedge clk) pin = 1'b1;
      for (int i = 0; i < 20 && !vld; i++) @(negedge clk);
      chk(vld && dat == 8'h14, "R5", "first stalled byte", dat, 8'h14);
      stable = 1'b1;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         if (!(vld && dat == 8'h14)) stable = 1'b0;
      end
      chk(stable, "R5", "held under backpressure", dat, 8'h14);
      c_code = 8'h2A;
      @(negedge clk) pin = 1'b0;
      cycles(6);
      pin = 1'b1;
      cycles(6);
      chk(vld && dat == 8'h14, "R10", "stalled byte after cfg change", dat, 8'h14);
      rdy = 1'b1;
      ex_clear();
      ex(8'h14); ex(8'h12); ex(8'h1C);
      ex(8'hF0); ex(8'h2A); ex(8'hF0); ex(8'h12); ex(8'hF0); ex(8'h14);
      ex(8'h14); ex(8'h12); ex(8'h2A);
      wait_bytes(base + 12, 60);
      check_seq("R6", "queued release and press", base);
      base = n;
      ex_clear();
      ex(8'hF0); ex(8'h2A); ex(8'hF0); ex(8'h12); ex(8'hF0); ex(8'h14);
      @(negedge clk) pin = 1'b0;
      cycles(25);
      check_seq("R10", "break with new code", base);
      c_code = 8'h1C;
   endtask

   // R7, R8, R9
   task automatic t_repeat();
      int base;
      c_ctrl = 0; c_alt = 0; c_shift = 1; c_pre = 1;
      c_dly = 2'd1; c_rte = 2'd2;
      base = n;
      @(negedge clk) pin = 1'b1;
      wait_bytes(base + 6, 400);
      ex_clear();
      ex(8'h12); ex(c_prec); ex(c_code); ex(c_code); ex(c_code); ex(c_code);
      check_seq("R8", "make then bare repeats", base);
      chk(log_t[base + 3] - log_t[base + 2] == 2 * DU + 1, "R7", "initial delay",
          log_t[base + 3] - log_t[base + 2], 2 * DU + 1);
      chk(log_t[base + 4] - log_t[base + 3] == 3 * RU + 1, "R8", "repeat interval",
          log_t[base + 4] - log_t[base + 3], 3 * RU + 1);
      chk(log_t[base + 5] - log_t[base + 4] == 3 * RU + 1, "R8", "repeat interval 2",
          log_t[base + 5] - log_t[base + 4], 3 * RU + 1);
      base = n;
      pin = 1'b0;
      ex_clear();
      ex(c_prec); ex(8'hF0); ex(c_code); ex(8'hF0); ex(8'h12);
      cycles(120);
      check_seq("R9", "release ends repeats", base);
      c_rte = 2'd0;
   endtask

   // R9: release swept across the timer expiry
   task automatic t_collide();
      bit saw_rep, saw_none;
      saw_rep = 1'b0; saw_none = 1'b0;
      c_ctrl = 0; c_alt = 0; c_shift = 0; c_pre = 0;
      c_dly = 2'd0; c_rte = 2'd0;
      for (int d = 10; d <= 24; d++) begin
         int base, k;
         bit ok;
         base = n;
         @(negedge clk) pin = 1'b1;
         wait_bytes(base + 1, 40);
         cycles(d);
         pin = 1'b0;
         cycles(60);
         k = n - base - 2;
         ok = (k >= 1);
         for (int i = 0; i < k && ok; i++) if (log_b[base + i] != c_code) ok = 1'b0;
         if (ok) ok = (log_b[base + k] == 8'hF0) && (log_b[base + k + 1] == c_code);
         chk(ok, "R9", "stream shape at release offset", k, d);
         if (k == 1) saw_none = 1'b1;
         if (k >= 2) saw_rep = 1'b1;
      end
      chk(saw_none && saw_rep, "R9", "both outcomes seen", saw_rep, 1);
   endtask

   initial begin
      cycles(4);
      rst_n = 1'b1;
      cycles(2);
      t_reset();
      t_bare();
      t_wrap(1, 1, 1, 1);
      t_wrap(0, 1, 0, 1);
      t_wrap(1, 0, 1, 0);
      t_stall();
      t_repeat();
      t_collide();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule